// File: doc/BRIEF.md
# Belt Operand Store with Call Frames

The block keeps recent results in a short queue called a belt. Each result written into it becomes position 0 of the frame now running, and every older entry of that frame moves one position along. Each stored entry carries the number of the frame that owns it. Reads name a logical position. They see only entries of the current frame, so an entry's position is its age among that frame's entries.

A call strobe starts a new frame. The values named by a list of argument positions are copied into that frame as its positions 0, 1, 2 and so on. The new frame holds nothing else. The copy happens at the clock edge, so the first callee cycle already reads the arguments and the call costs no cycles.

A return strobe goes back to the caller frame. The listed callee positions are copied into the caller frame as new youngest entries, and every callee entry is invalidated. Physical storage holds twice the logical belt length. Once it is full, the oldest entry falls out. Nothing is spilled to memory.

Top module: `belt_operand_store`

## Requirements
- R1: After reset the frame number is 0 and every read position returns valid 0 with data 0.
- R2: In a cycle with drop count k, lane d (d < k) becomes position d of the current frame after the clock edge. Every older entry of that frame moves up by k. Lanes at or above k are ignored.
- R3: Read results reflect only state from before the current cycle's edge. Drops presented in a cycle are not visible on the read ports until the following cycle.
- R4: Only positions 0 to BELT_LEN-1 are addressable. An entry pushed beyond position BELT_LEN-1 of its frame can no longer be read.
- R5: A call raises the frame number by 1. Callee position j (j below the transfer count) holds the caller value at transfer position j, read before the edge. All other callee positions read as invalid.
- R6: The call's remapping is visible on the read ports in the first cycle after the call edge.
- R7: Drops presented in a call cycle land in the caller frame, younger than its prior entries and older than nothing else. They are readable again after the return.
- R8: A return (call low) lowers the frame number by 1. Callee transfer position j becomes caller position j, and the caller's prior entries move up by the transfer count.
- R9: Drops presented in a return cycle are discarded. All entries of the exited frame are invalid, so a later call that reuses the frame number sees only its new arguments.
- R10: When call and return are both high, the call is performed and the return is ignored.
- R11: The frame number is FRAME_W bits wide and wraps. Entering a frame number clears every stale entry carrying that number.
- R12: A read of an empty position returns valid 0 and data 0. An argument copied from an empty position is a valid entry with data 0.
- R13: A drop count above DROP_N is treated as DROP_N, and a transfer count above ARG_N is treated as ARG_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drop_cnt_i | input | $clog2(DROP_N+1) | Number of results dropped this cycle |
| drop_data_i | input | DROP_N x DATA_W | Result values; lane 0 becomes position 0 |
| call_i | input | 1 | Enter a new frame |
| ret_i | input | 1 | Return to the caller frame |
| xfer_cnt_i | input | $clog2(ARG_N+1) | Argument or result count for call or return |
| xfer_pos_i | input | ARG_N x $clog2(BELT_LEN) | Source positions of arguments or results |
| rd_pos_i | input | RD_N x $clog2(BELT_LEN) | Read positions |
| rd_valid_o | output | RD_N | Read position holds an entry of the current frame |
| rd_data_o | output | RD_N x DATA_W | Read value, zero when not valid |
| frame_o | output | FRAME_W | Current frame number |

## Verification
The drop path is driven with single drops, paired drops, idle cycles and a run that fills more than the logical length. These patterns separate lane ordering errors, wrong shift amounts and a wrong visibility window. Calls and returns are driven with reordered argument lists and with drops in the same cycle. This shows whether arguments come from the pre-edge state, whether same-cycle drops go to the correct frame, and whether exited entries are really cleared. Simultaneous call and return, a full wrap of the frame counter and an over-range drop count cover the priority, aliasing and clamping corners.

// File: rtl/belt_pkg.sv
package belt_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2
  } frame_op_e;
endpackage

// File: rtl/belt_frame_ctr.sv
module belt_frame_ctr #(
  parameter int FRAME_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  belt_pkg::frame_op_e     op_i,
  output logic [FRAME_W-1:0]      frame_o,
  output logic [FRAME_W-1:0]      callee_o,
  output logic [FRAME_W-1:0]      caller_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
    end else begin
      case (op_i)
        belt_pkg::OP_CALL: frame_q <= frame_q + FRAME_W'(1);
        belt_pkg::OP_RET:  frame_q <= frame_q - FRAME_W'(1);
        default:           frame_q <= frame_q;
      endcase
    end
  end

  assign frame_o  = frame_q;
  assign callee_o = frame_q + FRAME_W'(1);
  assign caller_o = frame_q - FRAME_W'(1);
endmodule

// File: rtl/belt_rank.sv
module belt_rank #(
  parameter int PHYS    = 16,
  parameter int FRAME_W = 3,
  parameter int RANK_W  = 5
) (
  input  logic [PHYS-1:0]              vld_i,
  input  logic [PHYS-1:0][FRAME_W-1:0] tag_i,
  input  logic [FRAME_W-1:0]           frame_i,
  output logic [PHYS-1:0]              match_o,
  output logic [PHYS-1:0][RANK_W-1:0]  rank_o
);
  // rank = number of younger entries owned by the same frame
  logic [RANK_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < PHYS; i++) begin
      match_o[i] = vld_i[i] && (tag_i[i] == frame_i);
      rank_o[i]  = acc;
      acc        = acc + RANK_W'(match_o[i]);
    end
  end
endmodule

// File: rtl/belt_pick.sv
module belt_pick #(
  parameter int PHYS   = 16,
  parameter int DATA_W = 32,
  parameter int POS_W  = 3,
  parameter int RANK_W = 5
) (
  input  logic [PHYS-1:0]              match_i,
  input  logic [PHYS-1:0][RANK_W-1:0]  rank_i,
  input  logic [PHYS-1:0][DATA_W-1:0]  dat_i,
  input  logic [POS_W-1:0]             pos_i,
  output logic                         vld_o,
  output logic [DATA_W-1:0]            dat_o
);
  logic [PHYS-1:0] hit;

  always_comb begin
    dat_o = '0;
    for (int i = 0; i < PHYS; i++) begin
      hit[i] = match_i[i] && (rank_i[i] == RANK_W'(pos_i));
      if (hit[i]) dat_o = dat_o | dat_i[i];
    end
    vld_o = |hit;
  end

  // ranks from belt_rank must be unique per frame
  always_comb begin
    AST_ONE_HIT: assert ($onehot0(hit)); // R2
  end
endmodule

// File: rtl/belt_store.sv
module belt_store #(
  parameter int PHYS    = 16,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 3,
  parameter int MAXP    = 6,
  parameter int PCNT_W  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [PCNT_W-1:0]            push_cnt_i,
  input  logic [MAXP-1:0]              push_vld_i,
  input  logic [MAXP-1:0][FRAME_W-1:0] push_tag_i,
  input  logic [MAXP-1:0][DATA_W-1:0]  push_dat_i,
  input  logic                         kill_en_i,
  input  logic [FRAME_W-1:0]           kill_tag_i,
  output logic [PHYS-1:0]              vld_o,
  output logic [PHYS-1:0][FRAME_W-1:0] tag_o,
  output logic [PHYS-1:0][DATA_W-1:0]  dat_o
);
  logic [PHYS-1:0]              vld_q, vld_d, kept;
  logic [PHYS-1:0][FRAME_W-1:0] tag_q, tag_d;
  logic [PHYS-1:0][DATA_W-1:0]  dat_q, dat_d;

  always_comb begin
    for (int i = 0; i < PHYS; i++) begin
      kept[i] = vld_q[i] && !(kill_en_i && (tag_q[i] == kill_tag_i));
    end
    for (int i = 0; i < PHYS; i++) begin
      int src;
      int pi;
      src = i - int'(push_cnt_i);
      pi  = (i < MAXP) ? i : 0;
      if (i < int'(push_cnt_i)) begin
        vld_d[i] = push_vld_i[pi];
        tag_d[i] = push_tag_i[pi];
        dat_d[i] = push_dat_i[pi];
      end else begin
        vld_d[i] = kept[src];
        tag_d[i] = tag_q[src];
        dat_d[i] = dat_q[src];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tag_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      dat_q <= dat_d;
    end
  end

  assign vld_o = vld_q;
  assign tag_o = tag_q;
  assign dat_o = dat_q;

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_cnt_i == '0 && !kill_en_i) |=> ($stable(vld_q) && $stable(dat_q))); // R3
endmodule

// File: rtl/belt_operand_store.sv
module belt_operand_store #(
  parameter int BELT_LEN = 8,
  parameter int DROP_N   = 2,
  parameter int ARG_N    = 4,
  parameter int RD_N     = 2,
  parameter int DATA_W   = 32,
  parameter int FRAME_W  = 3,
  localparam int PHYS    = 2 * BELT_LEN,
  localparam int POS_W   = $clog2(BELT_LEN),
  localparam int DCNT_W  = $clog2(DROP_N + 1),
  localparam int XCNT_W  = $clog2(ARG_N + 1),
  localparam int MAXP    = DROP_N + ARG_N,
  localparam int PCNT_W  = $clog2(MAXP + 1),
  localparam int RANK_W  = $clog2(PHYS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [DCNT_W-1:0]              drop_cnt_i,
  input  logic [DROP_N-1:0][DATA_W-1:0]  drop_data_i,
  input  logic                           call_i,
  input  logic                           ret_i,
  input  logic [XCNT_W-1:0]              xfer_cnt_i,
  input  logic [ARG_N-1:0][POS_W-1:0]    xfer_pos_i,
  input  logic [RD_N-1:0][POS_W-1:0]     rd_pos_i,
  output logic [RD_N-1:0]                rd_valid_o,
  output logic [RD_N-1:0][DATA_W-1:0]    rd_data_o,
  output logic [FRAME_W-1:0]             frame_o
);
  import belt_pkg::*;

  frame_op_e                    op;
  logic [FRAME_W-1:0]           frame, callee, caller;
  logic [DCNT_W-1:0]            drop_n;
  logic [XCNT_W-1:0]            xfer_n;
  logic [PHYS-1:0]              st_vld, match;
  logic [PHYS-1:0][FRAME_W-1:0] st_tag;
  logic [PHYS-1:0][DATA_W-1:0]  st_dat;
  logic [PHYS-1:0][RANK_W-1:0]  rank;
  logic [ARG_N-1:0][DATA_W-1:0] xfer_dat;
  logic [ARG_N-1:0]             xfer_vld;
  logic [PCNT_W-1:0]            push_cnt;
  logic [MAXP-1:0]              push_vld;
  logic [MAXP-1:0][FRAME_W-1:0] push_tag;
  logic [MAXP-1:0][DATA_W-1:0]  push_dat;
  logic                         kill_en;
  logic [FRAME_W-1:0]           kill_tag;

  // call has priority over return
  assign op = call_i ? OP_CALL : (ret_i ? OP_RET : OP_NONE);

  assign drop_n = (int'(drop_cnt_i) > DROP_N) ? DCNT_W'(DROP_N) : drop_cnt_i;
  assign xfer_n = (int'(xfer_cnt_i) > ARG_N)  ? XCNT_W'(ARG_N)  : xfer_cnt_i;

  belt_frame_ctr #(.FRAME_W(FRAME_W)) i_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .frame_o  (frame),
    .callee_o (callee),
    .caller_o (caller)
  );

  belt_rank #(.PHYS(PHYS), .FRAME_W(FRAME_W), .RANK_W(RANK_W)) i_rank (
    .vld_i   (st_vld),
    .tag_i   (st_tag),
    .frame_i (frame),
    .match_o (match),
    .rank_o  (rank)
  );

  for (genvar r = 0; r < RD_N; r++) begin : g_rd
    belt_pick #(.PHYS(PHYS), .DATA_W(DATA_W), .POS_W(POS_W), .RANK_W(RANK_W)) i_pick (
      .match_i (match),
      .rank_i  (rank),
      .dat_i   (st_dat),
      .pos_i   (rd_pos_i[r]),
      .vld_o   (rd_valid_o[r]),
      .dat_o   (rd_data_o[r])
    );
    AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_valid_o[r] |-> (rd_data_o[r] == '0)); // R12
  end

  for (genvar a = 0; a < ARG_N; a++) begin : g_xfer
    belt_pick #(.PHYS(PHYS), .DATA_W(DATA_W), .POS_W(POS_W), .RANK_W(RANK_W)) i_pick (
      .match_i (match),
      .rank_i  (rank),
      .dat_i   (st_dat),
      .pos_i   (xfer_pos_i[a]),
      .vld_o   (xfer_vld[a]),
      .dat_o   (xfer_dat[a])
    );
  end

  // youngest first: transfers at slots 0.., then drops (call cycle only)
  always_comb begin
    push_vld = '0;
    push_tag = '0;
    push_dat = '0;
    push_cnt = '0;
    kill_en  = 1'b0;
    kill_tag = '0;
    case (op)
      OP_CALL: begin
        push_cnt = PCNT_W'(xfer_n) + PCNT_W'(drop_n);
        kill_en  = 1'b1;
        kill_tag = callee;
        for (int p = 0; p < MAXP; p++) begin
          int d;
          d = p - int'(xfer_n);
          if (p < int'(xfer_n)) begin
            push_vld[p] = 1'b1;
            push_tag[p] = callee;
            push_dat[p] = xfer_dat[(p < ARG_N) ? p : 0];
          end else if (d < int'(drop_n)) begin
            push_vld[p] = 1'b1;
            push_tag[p] = frame;
            push_dat[p] = drop_data_i[(d < DROP_N) ? d : 0];
          end
        end
      end
      OP_RET: begin
        push_cnt = PCNT_W'(xfer_n);
        kill_en  = 1'b1;
        kill_tag = frame;
        for (int p = 0; p < ARG_N; p++) begin
          if (p < int'(xfer_n)) begin
            push_vld[p] = 1'b1;
            push_tag[p] = caller;
            push_dat[p] = xfer_dat[p];
          end
        end
      end
      default: begin
        push_cnt = PCNT_W'(drop_n);
        for (int p = 0; p < DROP_N; p++) begin
          if (p < int'(drop_n)) begin
            push_vld[p] = 1'b1;
            push_tag[p] = frame;
            push_dat[p] = drop_data_i[p];
          end
        end
      end
    endcase
  end

  belt_store #(
    .PHYS(PHYS), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .MAXP(MAXP), .PCNT_W(PCNT_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_cnt_i (push_cnt),
    .push_vld_i (push_vld),
    .push_tag_i (push_tag),
    .push_dat_i (push_dat),
    .kill_en_i  (kill_en),
    .kill_tag_i (kill_tag),
    .vld_o      (st_vld),
    .tag_o      (st_tag),
    .dat_o      (st_dat)
  );

  assign frame_o = frame;

  AST_CALLEE_ARGS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> ($countones(match) == int'($past(xfer_n)))); // R5
  AST_RET_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i) |=> (frame_o == FRAME_W'($past(frame_o) - FRAME_W'(1)))); // R8
  AST_CALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i) |=> (frame_o == FRAME_W'($past(frame_o) + FRAME_W'(1)))); // R10
endmodule

// File: tb/test_belt_operand_store.sv
module test_belt_operand_store;
  localparam int DW = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      drop_cnt_i = '0;
  logic [1:0][DW-1:0] drop_data_i = '0;
  logic            call_i = 1'b0;
  logic            ret_i = 1'b0;
  logic [2:0]      xfer_cnt_i = '0;
  logic [3:0][2:0] xfer_pos_i = '0;
  logic [1:0][2:0] rd_pos_i = '0;
  logic [1:0]      rd_valid_o;
  logic [1:0][DW-1:0] rd_data_o;
  logic [2:0]      frame_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  belt_operand_store i_belt_operand_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .drop_cnt_i(drop_cnt_i), .drop_data_i(drop_data_i),
    .call_i(call_i), .ret_i(ret_i), .xfer_cnt_i(xfer_cnt_i), .xfer_pos_i(xfer_pos_i),
    .rd_pos_i(rd_pos_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .frame_o(frame_o)
  );

  typedef struct packed {
    logic [1:0] cnt;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [2:0] p0;
    logic [2:0] p1;
    logic       v0;
    logic [7:0] e0;
    logic       v1;
    logic [7:0] e1;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd1, 8'h11, 8'h00, 3'd0, 3'd1, 1'b1, 8'h11, 1'b0, 8'h00},
    '{2'd2, 8'h22, 8'h33, 3'd0, 3'd2, 1'b1, 8'h22, 1'b1, 8'h11},
    '{2'd0, 8'h00, 8'h00, 3'd1, 3'd3, 1'b1, 8'h33, 1'b0, 8'h00},
    '{2'd2, 8'h44, 8'h55, 3'd4, 3'd1, 1'b1, 8'h11, 1'b1, 8'h55},
    '{2'd2, 8'h66, 8'h77, 3'd6, 3'd5, 1'b1, 8'h11, 1'b1, 8'h33},
    '{2'd2, 8'h88, 8'h99, 3'd7, 3'd0, 1'b1, 8'h33, 1'b1, 8'h88}
  };

  task automatic chk_rd(input string req, input int port, input logic ev, input logic [7:0] ed);
    checks++;
    if (rd_valid_o[port] !== ev || rd_data_o[port] !== DW'(ed)) begin
      errors++;
      $display("FAIL %s port%0d: got v=%0d d=%h, expected v=%0d d=%h",
               req, port, rd_valid_o[port], rd_data_o[port], ev, ed);
    end
  endtask

  task automatic chk_frame(input string req, input int ef);
    checks++;
    if (int'(frame_o) != ef) begin
      errors++;
      $display("FAIL %s frame: got %0d, expected %0d", req, frame_o, ef);
    end
  endtask

  task automatic look(input int p0, input int p1);
    rd_pos_i[0] = 3'(p0);
    rd_pos_i[1] = 3'(p1);
    #1;
  endtask

  // drive at negedge, apply at posedge, clear controls just after
  task automatic cyc(input int dc, input logic [7:0] a, input logic [7:0] b,
                     input logic c, input logic r, input int xc,
                     input int x0, input int x1);
    @(negedge clk_i);
    drop_cnt_i = 2'(dc);
    drop_data_i[0] = DW'(a);
    drop_data_i[1] = DW'(b);
    call_i = c;
    ret_i = r;
    xfer_cnt_i = 3'(xc);
    xfer_pos_i[0] = 3'(x0);
    xfer_pos_i[1] = 3'(x1);
    @(posedge clk_i);
    #1;
    drop_cnt_i = '0;
    call_i = 1'b0;
    ret_i = 1'b0;
    xfer_cnt_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    look(0, 1);
    chk_frame("R1", 0);
    chk_rd("R1", 0, 1'b0, 8'h00);
    chk_rd("R1", 1, 1'b0, 8'h00);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      drop_cnt_i = VEC[i].cnt;
      drop_data_i[0] = DW'(VEC[i].d0);
      drop_data_i[1] = DW'(VEC[i].d1);
      @(posedge clk_i);
      #1;
      drop_cnt_i = '0;
      look(int'(VEC[i].p0), int'(VEC[i].p1));
      chk_rd((i == 5) ? "R4" : "R2", 0, VEC[i].v0, VEC[i].e0);
      chk_rd((i == 5) ? "R4" : "R2", 1, VEC[i].v1, VEC[i].e1);
    end
    // belt: 88 99 66 77 44 55 22 33

    // R3: same-cycle drop not yet visible
    @(negedge clk_i);
    drop_cnt_i = 2'd1;
    drop_data_i[0] = DW'(8'hAA);
    look(0, 1);
    chk_rd("R3", 0, 1'b1, 8'h88);
    @(posedge clk_i);
    #1;
    drop_cnt_i = '0;
    look(0, 1);
    chk_rd("R3", 0, 1'b1, 8'hAA);
    chk_rd("R3", 1, 1'b1, 8'h88);

    // call with args [pos2, pos0] and a same-cycle drop BB
    cyc(1, 8'hBB, 8'h00, 1'b1, 1'b0, 2, 2, 0);
    look(0, 1);
    chk_frame("R5", 1);
    chk_rd("R6", 0, 1'b1, 8'h99);
    chk_rd("R5", 1, 1'b1, 8'hAA);
    look(2, 7);
    chk_rd("R5", 0, 1'b0, 8'h00);
    chk_rd("R12", 1, 1'b0, 8'h00);

    cyc(1, 8'hC1, 8'h00, 1'b0, 1'b0, 0, 0, 0);
    // return result pos0 (C1), drop DD discarded
    cyc(1, 8'hDD, 8'h00, 1'b0, 1'b1, 1, 0, 0);
    look(0, 1);
    chk_frame("R8", 0);
    chk_rd("R8", 0, 1'b1, 8'hC1);
    chk_rd("R7", 1, 1'b1, 8'hBB);
    look(2, 7);
    chk_rd("R8", 0, 1'b1, 8'hAA);
    chk_rd("R9", 1, 1'b1, 8'h44);

    // re-enter frame 1: only the new argument
    cyc(0, 8'h00, 8'h00, 1'b1, 1'b0, 1, 1, 0);
    look(0, 1);
    chk_frame("R9", 1);
    chk_rd("R9", 0, 1'b1, 8'hBB);
    chk_rd("R9", 1, 1'b0, 8'h00);

    // call and return together
    cyc(0, 8'h00, 8'h00, 1'b1, 1'b1, 0, 0, 0);
    look(0, 1);
    chk_frame("R10", 2);
    chk_rd("R10", 0, 1'b0, 8'h00);
    cyc(0, 8'h00, 8'h00, 1'b0, 1'b1, 0, 0, 0);
    look(0, 1);
    chk_rd("R10", 0, 1'b1, 8'hBB);
    cyc(0, 8'h00, 8'h00, 1'b0, 1'b1, 0, 0, 0);
    look(0, 1);
    chk_frame("R8", 0);
    chk_rd("R8", 0, 1'b1, 8'hC1);

    // wrap: eight empty calls return to frame 0, stale entries cleared
    for (int k = 0; k < 8; k++) cyc(0, 8'h00, 8'h00, 1'b1, 1'b0, 0, 0, 0);
    look(0, 1);
    chk_frame("R11", 0);
    chk_rd("R11", 0, 1'b0, 8'h00);

    // over-range drop count clamps to two lanes
    cyc(3, 8'hE1, 8'hE2, 1'b0, 1'b0, 0, 0, 0);
    look(0, 1);
    chk_rd("R13", 0, 1'b1, 8'hE1);
    chk_rd("R13", 1, 1'b1, 8'hE2);
    look(2, 0);
    chk_rd("R13", 0, 1'b0, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule